// File: doc/BRIEF.md
# Idle Mode Clock Controller

This block decides when a small processor's core clock runs and when it is held off, while the peripheral clock keeps running. A sleep strobe, arriving while the idle-enable bit and the upper clock-select bit are both set, moves the controller from run into idle. In idle the core clock enable drops, the primary oscillator is told to shut down, and the peripherals carry on from the internal oscillator path.

The internal oscillator is requested when the frequency-select field is non-zero or the internal-source bit is set. A request starts a start-up counter, and the stable flag rises only when that counter expires. A request that was already stable before sleep keeps the flag set with no new delay. The watchdog and clock-monitor enables also keep the oscillator running, but they never set the stable flag.

A wake event starts a second counter, and the core clock comes back only when that counter expires. A wake event that arrives while the oscillator is still starting is held until the start-up interval completes.

Top module: `idleClkCtl`

## Requirements
- R1: In run, a sampled sleep strobe with `idleEn`=1 and `clkSel[1]`=1 makes `cpuClkEn` 0 from the next cycle. `perClkEn` stays 1 in every state.
- R2: `clkSel[0]` has no effect. A sleep strobe with `idleEn`=0, or with `clkSel[1]`=0, leaves `cpuClkEn` at 1.
- R3: Idle entry sets `priOscOff` to 1 and clears `oscStartOk` to 0 from the next cycle. Both keep these values after wake-up, until reset.
- R4: `intOscEn` is 1 exactly when `freqSel`≠0, `intSrcSel`=1, `wdtEn`=1 or `fscmEn`=1.
- R5: When the request (`freqSel`≠0 or `intSrcSel`=1) becomes present, `oscStable` rises after START_DLY clock edges. When the request goes away, `oscStable` clears on the next edge.
- R6: An `oscStable` that is already set stays set, with no drop, through idle entry when the request is held.
- R7: With `freqSel`=0 and `intSrcSel`=0, `oscStable` stays 0, even while `wdtEn` or `fscmEn` keeps `intOscEn` high.
- R8: A wake event sampled in idle, with the oscillator stable or not requested, brings `cpuClkEn` back to 1 exactly WAKE_DLY edges after the sampling edge. Until then `cpuClkEn` is 0.
- R9: A wake event sampled in idle while the request is present and not yet stable is held. `cpuClkEn` rises WAKE_DLY+1 edges after `oscStable` rises.
- R10: After reset: `cpuClkEn`=1, `perClkEn`=1, `priOscOff`=0, `oscStartOk`=1, `oscStable`=0. A wake event sampled in run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleepStrobe | input | 1 | One-cycle sleep request |
| idleEn | input | 1 | Idle enable |
| clkSel | input | 2 | System clock select; only bit 1 is used |
| freqSel | input | FREQ_W | Internal oscillator frequency select |
| intSrcSel | input | 1 | Internal-source select |
| wakeEvt | input | 1 | Wake event |
| wdtEn | input | 1 | Watchdog enabled |
| fscmEn | input | 1 | Fail-safe clock monitor enabled |
| cpuClkEn | output | 1 | Core clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| intOscEn | output | 1 | Internal oscillator run enable |
| priOscOff | output | 1 | Primary oscillator shutdown |
| oscStable | output | 1 | Internal oscillator stable flag |
| oscStartOk | output | 1 | Primary oscillator start status |

## Verification
A wrong controller state shows up on `cpuClkEn` one edge after the strobe or wake event that caused it. A counter that is off by one moves the `oscStable` rise, or the `cpuClkEn` rise, by exactly one cycle, so every check samples at the exact expected edge and one edge earlier. A lost pending wake leaves `cpuClkEn` low indefinitely, and the bench sees this at the computed release cycle. A stable flag that is not retained drops for a cycle during idle entry, and a per-cycle check catches that drop.

// File: rtl/idle_clk_pkg.sv
package idle_clk_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic enterIntIdle;
    logic wakeStart;
    logic wakeRun;
  } ctlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic stable;
    logic wakeDone;
  } dpStat_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAKE = 2'd2
  } idleState_t;
endpackage

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl
  import idle_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sleepStrobe,
  input  logic     idleEn,
  input  logic     selHi,
  input  logic     oscReq,
  input  logic     wakeEvt,
  input  dpStat_t  dpStat,
  output ctlStrb_t ctlStrb,
  output logic     cpuClkEn
);
  idleState_t state, stateNxt;
  logic pendWake, pendWakeNxt;
  logic enterIdle, wakeOk, wakeGo;

  assign enterIdle = (state == ST_RUN) && sleepStrobe && idleEn && selHi;
  assign wakeOk    = !oscReq || dpStat.stable;
  assign wakeGo    = (state == ST_IDLE) && (wakeEvt || pendWake) && wakeOk;

  always_comb begin
    stateNxt    = state;
    pendWakeNxt = pendWake;
    unique case (state)
      ST_RUN:  if (enterIdle) stateNxt = ST_IDLE;
      ST_IDLE: begin
        if (wakeGo) begin
          stateNxt    = ST_WAKE;
          pendWakeNxt = 1'b0;
        end else if (wakeEvt) begin
          pendWakeNxt = 1'b1;
        end
      end
      ST_WAKE: if (dpStat.wakeDone) stateNxt = ST_RUN;
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      pendWake <= 1'b0;
    end else begin
      state    <= stateNxt;
      pendWake <= pendWakeNxt;
    end
  end

  assign ctlStrb.enterIntIdle = enterIdle;
  assign ctlStrb.wakeStart    = wakeGo;
  assign ctlStrb.wakeRun      = (state == ST_WAKE);
  assign cpuClkEn             = (state == ST_RUN);

  // R1
  sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
    enterIdle |=> !cpuClkEn);
  // R2
  sleep_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuClkEn && sleepStrobe && !(idleEn && selHi)) |=> cpuClkEn);
  // R8
  wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctlStrb.wakeRun && !dpStat.wakeDone) |=> !cpuClkEn);
  // R9
  wake_pend_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && oscReq && !dpStat.stable) |=> !ctlStrb.wakeRun);
endmodule

// File: rtl/idle_clk_dp.sv
module idle_clk_dp
  import idle_clk_pkg::*;
#(
  parameter int START_DLY = 8,
  parameter int WAKE_DLY  = 5
) (
  input  logic     clk,
  input  logic     rst,
  input  ctlStrb_t ctlStrb,
  input  logic     oscReq,
  output dpStat_t  dpStat,
  output logic     priOscOff,
  output logic     oscStartOk,
  output logic     oscStable
);
  localparam int SCW = $clog2(START_DLY + 1);
  localparam int WCW = $clog2(WAKE_DLY + 1);
  localparam logic [SCW-1:0] START_LAST = SCW'(START_DLY - 1);
  localparam logic [WCW-1:0] WAKE_LAST  = WCW'(WAKE_DLY - 1);

  logic [SCW-1:0] startCnt;
  logic [WCW-1:0] wakeCnt;

  // start-up interval counter for the internal oscillator
  always_ff @(posedge clk) begin
    if (rst || !oscReq) begin
      startCnt  <= '0;
      oscStable <= 1'b0;
    end else if (!oscStable) begin
      if (startCnt == START_LAST) oscStable <= 1'b1;
      else                        startCnt  <= startCnt + 1'b1;
    end
  end

  // wake delay counter
  always_ff @(posedge clk) begin
    if (rst || ctlStrb.wakeStart)               wakeCnt <= '0;
    else if (ctlStrb.wakeRun && !dpStat.wakeDone) wakeCnt <= wakeCnt + 1'b1;
  end

  // primary oscillator control and its start status
  always_ff @(posedge clk) begin
    if (rst) begin
      priOscOff  <= 1'b0;
      oscStartOk <= 1'b1;
    end else if (ctlStrb.enterIntIdle) begin
      priOscOff  <= 1'b1;
      oscStartOk <= 1'b0;
    end
  end

  assign dpStat.stable   = oscStable;
  assign dpStat.wakeDone = ctlStrb.wakeRun && (wakeCnt == WAKE_LAST);

  // R3
  pri_off_chk: assert property (@(posedge clk) disable iff (rst)
    ctlStrb.enterIntIdle |=> (priOscOff && !oscStartOk));
  // R5
  stable_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !oscReq |=> !oscStable);
  // R6
  stable_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (oscStable && oscReq) |=> oscStable);
endmodule

// File: rtl/idleClkCtl.sv
module idleClkCtl
  import idle_clk_pkg::*;
#(
  parameter int FREQ_W    = 3,
  parameter int START_DLY = 8,
  parameter int WAKE_DLY  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleepStrobe,
  input  logic              idleEn,
  input  logic [1:0]        clkSel,
  input  logic [FREQ_W-1:0] freqSel,
  input  logic              intSrcSel,
  input  logic              wakeEvt,
  input  logic              wdtEn,
  input  logic              fscmEn,
  output logic              cpuClkEn,
  output logic              perClkEn,
  output logic              intOscEn,
  output logic              priOscOff,
  output logic              oscStable,
  output logic              oscStartOk
);
  ctlStrb_t ctlStrb;
  dpStat_t  dpStat;
  logic     oscReq;
  logic     selLoUnused;

  assign selLoUnused = clkSel[0];
  assign oscReq      = (freqSel != '0) || intSrcSel;
  assign intOscEn    = oscReq || wdtEn || fscmEn;
  assign perClkEn    = 1'b1;

  idle_clk_ctrl ctrl_i (
    .clk(clk), .rst(rst), .sleepStrobe(sleepStrobe), .idleEn(idleEn),
    .selHi(clkSel[1]), .oscReq(oscReq), .wakeEvt(wakeEvt),
    .dpStat(dpStat), .ctlStrb(ctlStrb), .cpuClkEn(cpuClkEn)
  );

  idle_clk_dp #(.START_DLY(START_DLY), .WAKE_DLY(WAKE_DLY)) dp_i (
    .clk(clk), .rst(rst), .ctlStrb(ctlStrb), .oscReq(oscReq),
    .dpStat(dpStat), .priOscOff(priOscOff), .oscStartOk(oscStartOk),
    .oscStable(oscStable)
  );

  // R7
  stable_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (freqSel == '0 && !intSrcSel) |=> !oscStable);
endmodule

// File: tb/idleClkCtl_tb_top.sv
module idleClkCtl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ_W = 3;
  localparam int START_DLY = 8;
  localparam int WAKE_DLY = 5;

  logic clk = 0;
  logic rst, sleepStrobe, idleEn, intSrcSel, wakeEvt, wdtEn, fscmEn;
  logic [1:0] clkSel;
  logic [FREQ_W-1:0] freqSel;
  logic cpuClkEn, perClkEn, intOscEn, priOscOff, oscStable, oscStartOk;
  int nRun = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idleClkCtl #(.FREQ_W(FREQ_W), .START_DLY(START_DLY), .WAKE_DLY(WAKE_DLY)) dut_i (
    .clk(clk), .rst(rst), .sleepStrobe(sleepStrobe), .idleEn(idleEn),
    .clkSel(clkSel), .freqSel(freqSel), .intSrcSel(intSrcSel), .wakeEvt(wakeEvt),
    .wdtEn(wdtEn), .fscmEn(fscmEn), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn),
    .intOscEn(intOscEn), .priOscOff(priOscOff), .oscStable(oscStable),
    .oscStartOk(oscStartOk)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rst = 1; sleepStrobe = 0; idleEn = 0; clkSel = 2'b00; freqSel = '0;
    intSrcSel = 0; wakeEvt = 0; wdtEn = 0; fscmEn = 0;
    tick(3);
    rst = 0;
  endtask

  task automatic sleepPulse(input logic ie, input logic [1:0] sel);
    idleEn = ie; clkSel = sel; sleepStrobe = 1;
    tick();
    sleepStrobe = 0;
  endtask

  task automatic testReset();
    doReset();
    check("R10 cpuClkEn", cpuClkEn, 1'b1);
    check("R10 perClkEn", perClkEn, 1'b1);
    check("R10 priOscOff", priOscOff, 1'b0);
    check("R10 oscStartOk", oscStartOk, 1'b1);
    check("R10 oscStable", oscStable, 1'b0);
    wakeEvt = 1; tick(); wakeEvt = 0; tick();
    check("R10 wake in run", cpuClkEn, 1'b1);
  endtask

  task automatic testIgnoredSleep();
    doReset();
    sleepPulse(1'b0, 2'b10);
    check("R2 idleEn=0", cpuClkEn, 1'b1);
    sleepPulse(1'b1, 2'b01);
    check("R2 clkSel[1]=0", cpuClkEn, 1'b1);
    check("R2 priOscOff", priOscOff, 1'b0);
    sleepPulse(1'b1, 2'b11);
    check("R2 clkSel[0] ignored", cpuClkEn, 1'b0);
  endtask

  task automatic testIdleAndWake();
    doReset();
    freqSel = 3'd4;
    sleepPulse(1'b1, 2'b10);
    check("R1 cpu off", cpuClkEn, 1'b0);
    check("R1 per on", perClkEn, 1'b1);
    check("R3 priOscOff", priOscOff, 1'b1);
    check("R3 oscStartOk", oscStartOk, 1'b0);
    tick(START_DLY - 2);
    check("R5 not yet stable", oscStable, 1'b0);
    tick();
    check("R5 stable", oscStable, 1'b1);
    wakeEvt = 1; tick(); wakeEvt = 0;
    tick(WAKE_DLY - 1);
    check("R8 still gated", cpuClkEn, 1'b0);
    check("R8 per on", perClkEn, 1'b1);
    tick();
    check("R8 cpu back", cpuClkEn, 1'b1);
    check("R3 priOscOff kept", priOscOff, 1'b1);
    check("R3 oscStartOk kept", oscStartOk, 1'b0);
    freqSel = '0; tick();
    check("R5 drop", oscStable, 1'b0);
  endtask

  task automatic testPendingWake();
    int remain;
    doReset();
    intSrcSel = 1;
    sleepPulse(1'b1, 2'b10);
    tick();
    wakeEvt = 1; tick(); wakeEvt = 0;
    remain = START_DLY + WAKE_DLY + 1 - 3;
    tick(remain - 1);
    check("R9 held", cpuClkEn, 1'b0);
    check("R9 stable by now", oscStable, 1'b1);
    tick();
    check("R9 released", cpuClkEn, 1'b1);
  endtask

  task automatic testStableKept();
    bit dropped = 0;
    doReset();
    freqSel = 3'd1;
    tick(START_DLY);
    check("R5 run stable", oscStable, 1'b1);
    idleEn = 1; clkSel = 2'b10; sleepStrobe = 1;
    for (int i = 0; i < 4; i++) begin
      tick(); sleepStrobe = 0;
      if (oscStable !== 1'b1) dropped = 1;
    end
    check("R6 no drop", dropped, 1'b0);
    wakeEvt = 1; tick(); wakeEvt = 0;
    tick(WAKE_DLY);
    check("R6 immediate wake", cpuClkEn, 1'b1);
  endtask

  task automatic testOscEnable();
    doReset();
    tick();
    check("R4 none", intOscEn, 1'b0);
    wdtEn = 1; tick();
    check("R4 wdt", intOscEn, 1'b1);
    tick(START_DLY + 2);
    check("R7 wdt no stable", oscStable, 1'b0);
    wdtEn = 0; fscmEn = 1; tick();
    check("R4 fscm", intOscEn, 1'b1);
    check("R7 fscm no stable", oscStable, 1'b0);
    fscmEn = 0; intSrcSel = 1; tick();
    check("R4 src", intOscEn, 1'b1);
    intSrcSel = 0; freqSel = 3'd2; tick();
    check("R4 freq", intOscEn, 1'b1);
    freqSel = '0; sleepPulse(1'b1, 2'b10);
    tick(START_DLY + 2);
    check("R7 idle no req", oscStable, 1'b0);
    wakeEvt = 1; tick(); wakeEvt = 0;
    tick(WAKE_DLY);
    check("R8 wake unrequested", cpuClkEn, 1'b1);
  endtask

  initial begin
    testReset();
    testIgnoredSleep();
    testIdleAndWake();
    testPendingWake();
    testStableKept();
    testOscEnable();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule